// File: doc/BRIEF.md
# UART Transmitter with Fractional Stop Length

This block is the transmit half of a serial channel. A one-character holding register feeds a shift register. Each character goes out as a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and then a high stop period. The stop period is set in sixteenths of a bit time. All timing comes from a sample-clock enable pulse, `tick16`, supplied from outside. In the normal mode sixteen pulses make one bit time. In the 1x mode a single pulse is one bit time.

Software sets the block up through two 8-bit mode registers that share one access port. An internal pointer selects which register the port reaches. The second register holds the stop-length code and two handshake controls. The first control is clear-to-send gating, which holds a ready character back until the CTS input is asserted. The second is automatic ready-to-send negation, which drops RTS one bit time after the line has fully drained once the transmitter has been disabled. Character length and parity come in on input pins. So do the enable, disable and RTS-set commands.

Top module: `uart_tx_frac`

## Requirements
- R1: After reset, txd is 1, rts is 0, hold_empty and shift_empty are 1, both mode registers read 0x00, and the pointer selects mode register 1.
- R2: Any access to mode register 1 moves the pointer to mode register 2. Accesses to mode register 2 leave the pointer unchanged. A pulse on mr_ptr_rst returns the pointer to mode register 1. A read returns the selected register on mr_rdata one cycle after the access. Mode register 2 holds the stop code in bits 3..0, CTS gating in bit 4 and RTS auto-negation in bit 5.
- R3: A frame is made of the following parts:
  - a start bit, low for 16 ticks;
  - char_len+5 data bits, sent LSB first (char_len values 0..3 give 5..8 bits);
  - when par_en is 1, a parity bit (par_type 00 = even, 01 = odd, 10 = forced 0, 11 = forced 1);
  - a high stop period.
- R4: For 6-, 7- and 8-bit characters, stop codes 0 to 7 give a stop period of code+9 ticks.
- R5: For 5-bit characters, stop codes 0 to 7 give a stop period of code+17 ticks.
- R6: Stop codes 8 to 15 give a stop period of code+17 ticks for every character length.
- R7: With one_x set, one tick is one bit time. The stop period is 1 bit when stop-code bit 3 is 0 and 2 bits when it is 1.
- R8: A character that is waiting in the holding register starts on the tick that ends the previous stop period. hold_empty is 1 from the clock edge on which the start bit begins. shift_empty is 0 while a frame is on the line.
- R9: With CTS gating on, a ready character is held back and txd stays high while cts is 0. The character starts on a tick at which cts is 1. A change of cts after a start bit has begun does not alter that frame.
- R10: rts is set by rts_set. When RTS auto-negation is on, CTS gating is off and the transmitter is disabled, rts falls exactly 16 ticks after the last stop period ends.
- R11: rts is never cleared while RTS auto-negation is off, or while CTS gating is also on.
- R12: After a disable command, the characters already in the holding and shift registers are still sent. A hold_we while disabled is ignored: hold_empty stays 1 and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample-clock enable (one bit time is 16 ticks, or 1 tick in the 1x mode) |
| one_x | input | 1 | Selects the 1x mode, in which one tick is one bit time |
| mr_acc | input | 1 | Mode register access strobe |
| mr_we | input | 1 | The access is a write |
| mr_wdata | input | 8 | Mode register write data |
| mr_ptr_rst | input | 1 | Returns the pointer to mode register 1 |
| mr_rdata | output | 8 | Mode register read data |
| char_len | input | 2 | Character length minus 5 |
| par_en | input | 1 | Enables the parity bit |
| par_type | input | 2 | Parity kind |
| tx_en | input | 1 | Enable command |
| tx_dis | input | 1 | Disable command (wins over tx_en) |
| rts_set | input | 1 | Sets rts |
| cts | input | 1 | Clear-to-send, 1 = asserted |
| hold_we | input | 1 | Write strobe for the holding register |
| hold_data | input | 8 | Character to send |
| txd | output | 1 | Serial output |
| rts | output | 1 | Ready-to-send output |
| hold_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | Shift register is empty and no frame is on the line |

## Verification
A wrong tick count or a wrong stop-code decode shows up as a change in the spacing between consecutive start edges of back-to-back characters. That spacing is off by the error within a single frame time. A bad shift or parity state corrupts the bit sampled at the middle of the affected bit, so the first frame after the fault gives it away. Faults in the handshake state have different signatures:
- a wrong enable state shows as frames that appear, or fail to appear, after writes made while disabled;
- a CTS gating fault shows as a start edge while cts is low;
- a drain tracker fault shows as an rts fall that lands at the wrong tick, or that never comes, about one bit time after the line goes quiet.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HANG
  } tx_state_t;

  localparam logic [1:0] PAR_EVEN  = 2'b00;
  localparam logic [1:0] PAR_ODD   = 2'b01;
  localparam logic [1:0] PAR_ZERO  = 2'b10;
  localparam logic [1:0] PAR_ONE   = 2'b11;
endpackage

// File: rtl/tx_mode_regs.sv
module tx_mode_regs #(
  parameter int REG_W = 8,
  parameter int NREGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             ptr_rst,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] mr2
);
  localparam int PTR_W = $clog2(NREGS);

  logic [REG_W-1:0] regs_q [NREGS];
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      rdata <= '0;
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      if (acc) begin
        if (we) regs_q[ptr_q] <= wdata;
        else    rdata <= regs_q[ptr_q];
      end
      if (ptr_rst)
        ptr_q <= '0;
      else if (acc && ptr_q != PTR_W'(NREGS-1))
        ptr_q <= ptr_q + 1'b1;
    end
  end

  assign mr2 = regs_q[NREGS-1];

  // R2: an access to the first register advances the pointer
  p_ptr_adv_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && ptr_q == '0 && !ptr_rst) |=> (ptr_q == PTR_W'(1)));
  // R2: accesses to the last register keep the pointer where it is
  p_ptr_stay_r2: assert property (@(posedge clk) disable iff (rst)
    (ptr_q == PTR_W'(NREGS-1) && !ptr_rst) |=> (ptr_q == PTR_W'(NREGS-1)));
endmodule

// File: rtl/tx_stop_len.sv
module tx_stop_len #(
  parameter int OVS   = 16,
  parameter int CNT_W = $clog2(2*OVS+1)
) (
  input  logic [3:0]       code,
  input  logic             len5,
  input  logic             one_x,
  output logic [CNT_W-1:0] stop_ticks
);
  localparam logic [CNT_W-1:0] LONG_BASE  = CNT_W'(OVS + 1);
  localparam logic [CNT_W-1:0] SHORT_BASE = CNT_W'(OVS/2 + 1);

  always_comb begin
    if (one_x)
      stop_ticks = code[3] ? CNT_W'(2) : CNT_W'(1);
    else if (code[3] || len5)
      stop_ticks = CNT_W'(code) + LONG_BASE;
    else
      stop_ticks = CNT_W'(code) + SHORT_BASE;
  end
endmodule

// File: rtl/tx_engine.sv
module tx_engine
  import uart_tx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DW    = 8,
  parameter int CNT_W = $clog2(2*OVS+1),
  parameter int BIT_W = $clog2(DW+2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             one_x,
  input  logic [1:0]       len,
  input  logic             par_en,
  input  logic [1:0]       par_type,
  input  logic [CNT_W-1:0] stop_ticks,
  input  logic             gate_cts,
  input  logic             rts_auto_cfg,
  input  logic             en_cmd,
  input  logic             dis_cmd,
  input  logic             rts_set,
  input  logic             cts,
  input  logic             hold_we,
  input  logic [DW-1:0]    hold_data,
  output logic             txd,
  output logic             rts,
  output logic             hold_empty,
  output logic             shift_empty
);
  tx_state_t        st_q;
  logic [DW-1:0]    hold_q;
  logic             hold_full_q, en_q, txd_q, rts_q;
  logic [DW:0]      sh_q;
  logic [BIT_W-1:0] left_q;
  logic [CNT_W-1:0] cnt_q, stop_q;

  logic [BIT_W-1:0] nbits, nb_total;
  logic [DW-1:0]    mask, data_m;
  logic             par_bit, rts_auto, can_go, bt_last, stop_done, drained, load;
  logic [DW:0]      frame_c;

  always_comb begin
    nbits    = BIT_W'(len) + BIT_W'(5);
    nb_total = nbits + BIT_W'(par_en);
    mask     = {DW{1'b1}} >> (2'd3 - len);
    data_m   = hold_q & mask;
    case (par_type)
      PAR_EVEN: par_bit = ^data_m;
      PAR_ODD:  par_bit = ~^data_m;
      PAR_ZERO: par_bit = 1'b0;
      default:  par_bit = 1'b1;
    endcase
    frame_c        = {1'b0, data_m};
    frame_c[nbits] = par_bit;
  end

  assign rts_auto  = rts_auto_cfg && !gate_cts;
  assign can_go    = hold_full_q && (!gate_cts || cts);
  assign bt_last   = one_x ? 1'b1 : (cnt_q == CNT_W'(OVS-1));
  assign stop_done = (cnt_q == stop_q - 1'b1);
  assign drained   = !en_q && rts_auto && rts_q && !hold_full_q;
  assign load      = tick && can_go &&
                     (st_q == ST_IDLE || (st_q == ST_STOP && stop_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      en_q        <= 1'b0;
      txd_q       <= 1'b1;
      rts_q       <= 1'b0;
      sh_q        <= '0;
      left_q      <= '0;
      cnt_q       <= '0;
      stop_q      <= CNT_W'(1);
    end else begin
      if (dis_cmd)     en_q <= 1'b0;
      else if (en_cmd) en_q <= 1'b1;
      if (rts_set) rts_q <= 1'b1;

      if (load) hold_full_q <= 1'b0;
      if (hold_we && en_q && (!hold_full_q || load)) begin
        hold_q      <= hold_data;
        hold_full_q <= 1'b1;
      end

      if (load) begin
        st_q   <= ST_START;
        txd_q  <= 1'b0;
        cnt_q  <= '0;
        sh_q   <= frame_c;
        left_q <= nb_total - 1'b1;
        stop_q <= stop_ticks;
      end else if (tick) begin
        unique case (st_q)
          ST_IDLE: begin
            cnt_q <= '0;
            if (drained) st_q <= ST_HANG;
          end
          ST_START: begin
            if (bt_last) begin
              st_q  <= ST_DATA;
              txd_q <= sh_q[0];
              sh_q  <= sh_q >> 1;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (bt_last) begin
              cnt_q <= '0;
              if (left_q == '0) begin
                st_q  <= ST_STOP;
                txd_q <= 1'b1;
              end else begin
                txd_q  <= sh_q[0];
                sh_q   <= sh_q >> 1;
                left_q <= left_q - 1'b1;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (stop_done) begin
              cnt_q <= '0;
              st_q  <= drained ? ST_HANG : ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_HANG: begin
            if (bt_last) begin
              cnt_q <= '0;
              st_q  <= ST_IDLE;
              if (rts_auto) rts_q <= 1'b0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign txd         = txd_q;
  assign rts         = rts_q;
  assign hold_empty  = !hold_full_q;
  assign shift_empty = (st_q == ST_IDLE) || (st_q == ST_HANG);

  // R3: the line only moves on a sample tick
  p_txd_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd_q) |-> $past(tick));
  // R9: no start while gated and CTS negated
  p_cts_block_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && gate_cts && !cts && st_q == ST_IDLE) |=> (st_q != ST_START));
  // R10: rts only falls under auto negation while disabled
  p_rts_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rts_q) |-> $past(rts_auto && !en_q));
  // R11: with auto negation off rts holds once set
  p_rts_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (!rts_auto_cfg && rts_q) |=> rts_q);
  // R12: a disabled block never fills its holding register
  p_hold_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !hold_full_q) |=> !hold_full_q);
endmodule

// File: rtl/uart_tx_frac.sv
module uart_tx_frac #(
  parameter int OVS   = 16,
  parameter int DW    = 8,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16,
  input  logic             one_x,
  input  logic             mr_acc,
  input  logic             mr_we,
  input  logic [REG_W-1:0] mr_wdata,
  input  logic             mr_ptr_rst,
  output logic [REG_W-1:0] mr_rdata,
  input  logic [1:0]       char_len,
  input  logic             par_en,
  input  logic [1:0]       par_type,
  input  logic             tx_en,
  input  logic             tx_dis,
  input  logic             rts_set,
  input  logic             cts,
  input  logic             hold_we,
  input  logic [DW-1:0]    hold_data,
  output logic             txd,
  output logic             rts,
  output logic             hold_empty,
  output logic             shift_empty
);
  localparam int CNT_W = $clog2(2*OVS+1);

  logic [REG_W-1:0] mr2;
  logic [CNT_W-1:0] stop_ticks;

  tx_mode_regs #(.REG_W(REG_W), .NREGS(2)) u_regs (
    .clk(clk), .rst(rst), .acc(mr_acc), .we(mr_we), .wdata(mr_wdata),
    .ptr_rst(mr_ptr_rst), .rdata(mr_rdata), .mr2(mr2)
  );

  tx_stop_len #(.OVS(OVS), .CNT_W(CNT_W)) u_stop (
    .code(mr2[3:0]), .len5(char_len == 2'd0), .one_x(one_x),
    .stop_ticks(stop_ticks)
  );

  tx_engine #(.OVS(OVS), .DW(DW), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .tick(tick16), .one_x(one_x), .len(char_len),
    .par_en(par_en), .par_type(par_type), .stop_ticks(stop_ticks),
    .gate_cts(mr2[4]), .rts_auto_cfg(mr2[5]), .en_cmd(tx_en),
    .dis_cmd(tx_dis), .rts_set(rts_set), .cts(cts), .hold_we(hold_we),
    .hold_data(hold_data), .txd(txd), .rts(rts), .hold_empty(hold_empty),
    .shift_empty(shift_empty)
  );
endmodule

// File: tb/uart_tx_frac_tb_top.sv
module uart_tx_frac_tb_top;
  logic clk = 1'b0, rst = 1'b1, tick16 = 1'b0, one_x = 1'b0;
  logic mr_acc = 1'b0, mr_we = 1'b0, mr_ptr_rst = 1'b0;
  logic [7:0] mr_wdata = '0, mr_rdata, hold_data = '0;
  logic [1:0] char_len = 2'd3, par_type = 2'd0;
  logic par_en = 1'b0, tx_en = 1'b0, tx_dis = 1'b0, rts_set = 1'b0;
  logic cts = 1'b1, hold_we = 1'b0;
  logic txd, rts, hold_empty, shift_empty;

  uart_tx_frac dut_i (
    .clk(clk), .rst(rst), .tick16(tick16), .one_x(one_x), .mr_acc(mr_acc),
    .mr_we(mr_we), .mr_wdata(mr_wdata), .mr_ptr_rst(mr_ptr_rst),
    .mr_rdata(mr_rdata), .char_len(char_len), .par_en(par_en),
    .par_type(par_type), .tx_en(tx_en), .tx_dis(tx_dis), .rts_set(rts_set),
    .cts(cts), .hold_we(hold_we), .hold_data(hold_data), .txd(txd),
    .rts(rts), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  always #10 clk = ~clk;

  typedef struct {
    int d; int n; bit pe; bit pb; int bt; int stopt; bit chk; string tag;
  } item_t;
  item_t sb_q[$];

  int total = 0, bad = 0, cfg_sb = 0;
  int tk = 0, ph = 0, frames = 0, last_fall = 0, rts_fall_tk = -1;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generator and scoreboard monitor
  bit inframe = 0, have_prev = 0, prev_txd = 1, prev_rts = 0, mism = 0;
  int fall_tk = 0, bidx = 0;
  item_t cur, prv;
  always @(negedge clk) begin
    if (tick16 && !rst) begin
      tk++;
      if (prev_rts && !rts) rts_fall_tk = tk;
      prev_rts = rts;
      if (!inframe && prev_txd && !txd) begin
        if (have_prev && prv.chk)
          chk(tk - fall_tk == (1 + prv.n + prv.pe) * prv.bt + prv.stopt,
              {prv.tag, " R8 start spacing"}, tk - fall_tk,
              (1 + prv.n + prv.pe) * prv.bt + prv.stopt);
        chk(hold_empty && !shift_empty, "R8 flags at start",
            {hold_empty, shift_empty}, 2);
        if (sb_q.size() == 0) begin
          chk(0, "R12 unexpected frame", 1, 0);
          cur = '{0, 8, 0, 0, 16, 9, 0, "R12"};
        end else cur = sb_q.pop_front();
        fall_tk = tk; inframe = 1; bidx = 0; mism = 0; frames++;
        last_fall = tk;
      end
      if (inframe && (tk - fall_tk) == bidx * cur.bt + cur.bt / 2) begin
        if (bidx == 0) mism |= txd;
        else if (bidx <= cur.n) mism |= (txd != cur.d[bidx-1]);
        else if (cur.pe && bidx == cur.n + 1) mism |= (txd != cur.pb);
        else begin
          chk(!mism, "R3 frame content", cur.d, cur.d);
          chk(txd, "R3 stop level", txd, 1);
          inframe = 0; prv = cur; have_prev = 1;
        end
        bidx++;
      end
      prev_txd = txd;
    end
    ph = (ph + 1) % 4;
    tick16 = (ph == 0);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ticks(int n);
    int t0 = tk;
    while (tk < t0 + n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic mr_access(bit wr, logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk); mr_acc = 1; mr_we = wr; mr_wdata = wd;
    @(negedge clk); mr_acc = 0; mr_we = 0; rd = mr_rdata;
  endtask

  task automatic set_mr2(logic [7:0] v);
    logic [7:0] dummy;
    pulse(mr_ptr_rst);
    mr_access(0, 8'h00, dummy);
    mr_access(1, v, dummy);
    cfg_sb = v[3:0];
  endtask

  task automatic send(int d, bit chkp, string tag);
    item_t it;
    int n = char_len + 5;
    int dm = d & ((1 << n) - 1);
    bit x = ^dm[7:0];
    it.d = dm; it.n = n; it.pe = par_en; it.chk = chkp; it.tag = tag;
    it.pb = (par_type == 0) ? x : (par_type == 1) ? !x : par_type[0];
    it.bt = one_x ? 1 : 16;
    if (one_x) it.stopt = (cfg_sb >= 8) ? 2 : 1;
    else it.stopt = (cfg_sb >= 8 || n == 5) ? cfg_sb + 17 : cfg_sb + 9;
    sb_q.push_back(it);
    do @(negedge clk); while (!hold_empty);
    hold_we = 1; hold_data = d[7:0];
    @(negedge clk); hold_we = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(hold_empty && shift_empty));
    wait_ticks(40);
  endtask

  task automatic burst(int len_code, bit pe, int pt, logic [7:0] mr2v,
                       string tag);
    wait_idle();
    char_len = len_code[1:0]; par_en = pe; par_type = pt[1:0];
    set_mr2(mr2v);
    send(8'hA5, 1, tag);
    send(8'h3C, 1, tag);
    send(8'hD2, 0, tag);
    wait_idle();
  endtask

  initial begin
    logic [7:0] rd;
    int f0;
    cyc(5); rst = 0; cyc(2);
    // R1: reset state
    chk(txd && !rts && hold_empty && shift_empty, "R1 reset outputs",
        {txd, rts, hold_empty, shift_empty}, 4'b1011);
    mr_access(0, 0, rd); chk(rd == 8'h00, "R1 mode reg 1 reset", rd, 0);
    mr_access(0, 0, rd); chk(rd == 8'h00, "R1 mode reg 2 reset", rd, 0);
    // R2: pointer behaviour
    mr_access(1, 8'h3C, rd);
    mr_access(0, 0, rd); chk(rd == 8'h3C, "R2 pointer stays on reg 2", rd, 8'h3C);
    pulse(mr_ptr_rst);
    mr_access(1, 8'hA5, rd);
    mr_access(0, 0, rd); chk(rd == 8'h3C, "R2 pointer advanced", rd, 8'h3C);
    pulse(mr_ptr_rst);
    mr_access(0, 0, rd); chk(rd == 8'hA5, "R2 pointer reset", rd, 8'hA5);

    pulse(tx_en);
    burst(3, 0, 0, 8'h00, "R4");   // 8 bits, 9 ticks
    burst(3, 1, 1, 8'h07, "R4");   // 8 bits odd, 16 ticks
    burst(0, 1, 0, 8'h00, "R5");   // 5 bits even, 17 ticks
    burst(0, 0, 0, 8'h03, "R5");   // 5 bits, 20 ticks
    burst(1, 1, 1, 8'h0F, "R6");   // 6 bits odd, 32 ticks
    burst(2, 1, 3, 8'h04, "R4");   // 7 bits forced 1, 13 ticks
    burst(0, 1, 2, 8'h08, "R6");   // 5 bits forced 0, 25 ticks
    one_x = 1;
    burst(3, 1, 0, 8'h00, "R7");   // 1x, one stop bit
    burst(2, 0, 0, 8'h08, "R7");   // 1x, two stop bits
    one_x = 0;

    // R9: CTS gating
    burst(3, 0, 0, 8'h00, "R4");
    set_mr2(8'h10); cts = 0; f0 = frames;
    send(8'h55, 0, "R9");
    wait_ticks(100);
    chk(frames == f0 && txd && !hold_empty, "R9 held while cts low",
        frames - f0, 0);
    cts = 1;
    while (frames == f0) @(negedge clk);
    send(8'h33, 0, "R9");
    while (frames == f0 + 1) @(negedge clk);
    cts = 0;
    send(8'h0F, 0, "R9");
    wait_ticks(400);
    chk(frames == f0 + 2 && shift_empty && !hold_empty,
        "R9 third held, second unaffected", frames - f0, 2);
    cts = 1;
    wait_idle();
    chk(frames == f0 + 3, "R9 released", frames - f0, 3);

    // R10 and R12: auto negation after drain
    set_mr2(8'h20); pulse(rts_set);
    chk(rts, "R10 rts set", rts, 1);
    f0 = frames; rts_fall_tk = -1;
    send(8'hC3, 1, "R12");
    send(8'h81, 0, "R12");
    pulse(tx_dis);
    wait_idle();
    wait_ticks(40);
    chk(frames == f0 + 2, "R12 drain after disable", frames - f0, 2);
    chk(rts_fall_tk - last_fall == 153 + 16, "R10 rts fall timing",
        rts_fall_tk - last_fall, 169);
    chk(!rts, "R10 rts low", rts, 0);
    @(negedge clk); hold_we = 1; hold_data = 8'h77;
    @(negedge clk); hold_we = 0;
    cyc(2);
    chk(hold_empty, "R12 write ignored (flag)", hold_empty, 1);
    wait_ticks(300);
    chk(frames == f0 + 2, "R12 write ignored (line)", frames - f0, 2);

    // R11: auto negation off, and with gating on
    set_mr2(8'h00); pulse(tx_en); pulse(rts_set);
    send(8'h12, 0, "R11"); pulse(tx_dis);
    wait_idle(); wait_ticks(100);
    chk(rts, "R11 rts kept, auto off", rts, 1);
    set_mr2(8'h30); pulse(tx_en);
    send(8'h21, 0, "R11"); pulse(tx_dis);
    wait_idle(); wait_ticks(100);
    chk(rts, "R11 rts kept, gating on", rts, 1);
    chk(sb_q.size() == 0, "R3 all frames seen", sb_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule